// File: doc/BRIEF.md
# Register Rename Map with Free-List Allocator

This block renames one instruction per cycle for an out-of-order core. Each instruction names two architectural source registers and optionally one architectural destination. The block returns the physical tag currently bound to each source. When there is a destination, it also returns a freshly allocated physical tag and binds the destination name to that tag from the next cycle on. Because every write gets a new physical location, write-after-read and write-after-write conflicts on architectural names disappear. Read-after-write links are kept, because a later reader always sees the tag of the latest earlier writer.

Unallocated physical tags wait in a first-in first-out free list. After reset, architectural name i is bound to physical tag i, and the tags from the number of architectural names up to the last physical tag sit in the free list in ascending order. With the default sizing of 4 names and 8 tags, the free list holds tags 4, 5, 6 and 7. A release port hands back one retired tag per cycle to the tail of the list. When an instruction needs a tag and none is free, the block holds off the instruction and changes nothing.

Top module: `reg_rename`

## Requirements
- R1: After reset, a lookup of architectural name i returns physical tag i for every name, and the first four allocations return tags 4, 5, 6 and 7 in that order (default sizing).
- R2: The source tags are combinational functions of the current map. A later reader of a name gets the tag allocated to the latest earlier accepted writer of that name.
- R3: Source lookups use the map as it stood before the same instruction's destination update. An instruction whose source and destination are the same name receives the old tag for that source.
- R4: An instruction is accepted when in_valid and in_ready are both 1. If it has a destination, dst_tag equals the head of the free list in that cycle, and from the next cycle on the destination name maps to that tag.
- R5: Tags are handed out strictly in free-list order. For destinations r2, r2, r2 and r1 after reset, dst_tag is 4, 5, 6 and 7 in turn.
- R6: in_ready is 0 exactly when in_has_dst is 1 and the free list is empty. In that cycle neither the map nor the free list changes.
- R7: An instruction with in_has_dst = 0 takes no free-list entry, updates no map entry, and is accepted even when the free list is empty.
- R8: A tag given on the release port (rel_valid = 1) joins the tail of the free list. It is handed out only after every tag that was already in the list.
- R9: A release and an allocation in the same cycle both take effect. The allocation takes the old head, and the released tag joins the tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented |
| in_has_dst | input | 1 | The instruction writes a destination |
| in_src_a | input | $clog2(ARCH_REGS) | First source architectural name |
| in_src_b | input | $clog2(ARCH_REGS) | Second source architectural name |
| in_dst | input | $clog2(ARCH_REGS) | Destination architectural name |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| src_a_tag | output | $clog2(PHYS_REGS) | Physical tag for the first source |
| src_b_tag | output | $clog2(PHYS_REGS) | Physical tag for the second source |
| dst_tag | output | $clog2(PHYS_REGS) | Newly allocated tag (head of free list) |
| rel_valid | input | 1 | A physical tag is returned this cycle |
| rel_tag | input | $clog2(PHYS_REGS) | The returned physical tag |

## Verification
A corrupted map entry shows up as a wrong source tag in the first cycle any instruction names that register. A wrong write lands on some name's entry and shows up in the cycle after the write. A free list that loses, duplicates or reorders a tag shows up as a wrong dst_tag at the next allocation that reaches that slot. A wrong occupancy count shows up as in_ready falling too early or too late. The bench compares every output against a queue-based model in every cycle, so each such fault is reported in the first cycle it becomes visible at the ports.

// File: rtl/rn_pkg.sv
package rn_pkg;

  // Tag found at free-list slot k right after reset.
  function automatic int unsigned boot_free_tag(int unsigned k, int unsigned arch_regs);
    return arch_regs + k;
  endfunction

  // Circular pointer advance.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int ARCH_REGS = 4,
  parameter int PHYS_REGS = 8,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a_idx,
  input  logic [AW-1:0] rd_b_idx,
  output logic [PW-1:0] rd_a_tag,
  output logic [PW-1:0] rd_b_tag,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [PW-1:0] wr_tag
);

  logic [PW-1:0] map_q [ARCH_REGS];

  // Reads see the registered state only, never the write of this cycle.
  assign rd_a_tag = map_q[rd_a_idx];
  assign rd_b_tag = map_q[rd_b_idx];

  for (genvar i = 0; i < ARCH_REGS; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        map_q[i] <= PW'(i);
      else if (wr_en && (wr_idx == AW'(i)))
        map_q[i] <= wr_tag;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_idx)] == $past(wr_tag)); // R4

endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int ARCH_REGS = 4,
  parameter int PHYS_REGS = 8,
  localparam int PW    = $clog2(PHYS_REGS),
  localparam int DEPTH = PHYS_REGS,
  localparam int INIT  = PHYS_REGS - ARCH_REGS,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  output logic [PW-1:0] head_tag,
  output logic          empty,
  input  logic          push,
  input  logic [PW-1:0] push_tag
);
  import rn_pkg::*;

  logic [PW-1:0] slot_q [DEPTH];
  logic [IW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;

  assign head_tag = slot_q[rd_q];
  assign empty    = (cnt_q == '0);

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[k] <= (k < INIT) ? PW'(boot_free_tag(k, ARCH_REGS)) : '0;
      else if (push && (wr_q == IW'(k)))
        slot_q[k] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= IW'(INIT % DEPTH);
      cnt_q <= CW'(INIT);
    end else begin
      if (pop)  rd_q <= IW'(ring_next(int'(rd_q), DEPTH));
      if (push) wr_q <= IW'(ring_next(int'(wr_q), DEPTH));
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q != CW'(DEPTH)) || pop); // R8
  AST_BOTH_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> cnt_q == $past(cnt_q)); // R9

endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int ARCH_REGS = 4,
  parameter int PHYS_REGS = 8,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_has_dst,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic [AW-1:0] in_dst,
  output logic          in_ready,
  output logic [PW-1:0] src_a_tag,
  output logic [PW-1:0] src_b_tag,
  output logic [PW-1:0] dst_tag,
  input  logic          rel_valid,
  input  logic [PW-1:0] rel_tag
);

  // Named internal events, observed by the assertions.
  logic free_empty;
  logic accept;
  logic alloc_pop;

  assign in_ready  = !(in_has_dst && free_empty);
  assign accept    = in_valid && in_ready;
  assign alloc_pop = accept && in_has_dst;

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (in_src_a),
    .rd_b_idx (in_src_b),
    .rd_a_tag (src_a_tag),
    .rd_b_tag (src_b_tag),
    .wr_en    (alloc_pop),
    .wr_idx   (in_dst),
    .wr_tag   (dst_tag)
  );

  rn_free_fifo #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc_pop),
    .head_tag (dst_tag),
    .empty    (free_empty),
    .push     (rel_valid),
    .push_tag (rel_tag)
  );

  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |-> (in_has_dst && free_empty && !alloc_pop)); // R6
  AST_NODST_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_has_dst) |-> (in_ready && !alloc_pop)); // R7
  AST_SRC_PRE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_pop && in_src_a == in_dst) |-> src_a_tag != dst_tag); // R3

endmodule

// File: tb/reg_rename_test.sv
module reg_rename_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 4;
  localparam int NP = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_has_dst = 0, rel_valid = 0;
  logic [1:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
  logic [2:0] rel_tag = 0;
  logic in_ready;
  logic [2:0] src_a_tag, src_b_tag, dst_tag;

  int nchk = 0, nfail = 0;
  bit done = 0;
  int mdl_map [NA];
  int fl[$];
  int retire[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_rename #(.ARCH_REGS(NA), .PHYS_REGS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_has_dst(in_has_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst),
    .in_ready(in_ready), .src_a_tag(src_a_tag), .src_b_tag(src_b_tag),
    .dst_tag(dst_tag), .rel_valid(rel_valid), .rel_tag(rel_tag));

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive after negedge, compare mid-cycle, update model at posedge.
  task automatic step(bit v, bit hd, int a, int b, int d, bit rv, int rt, string req);
    bit exp_rdy;
    in_valid = v; in_has_dst = hd; in_src_a = 2'(a); in_src_b = 2'(b);
    in_dst = 2'(d); rel_valid = rv; rel_tag = 3'(rt);
    #1;
    exp_rdy = !(hd && fl.size() == 0);
    chk(req, "in_ready", int'(in_ready), int'(exp_rdy));
    chk(req, "src_a_tag", int'(src_a_tag), mdl_map[a]);
    chk(req, "src_b_tag", int'(src_b_tag), mdl_map[b]);
    if (hd && fl.size() > 0) chk(req, "dst_tag", int'(dst_tag), fl[0]);
    @(posedge clk);
    if (v && hd && exp_rdy) begin
      retire.push_back(mdl_map[d]);
      mdl_map[d] = fl.pop_front();
    end
    if (rv) fl.push_back(rt);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) mdl_map[i] = i;
    for (int t = NA; t < NP; t++) fl.push_back(t);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1: reset bindings and first free tag
    step(0, 0, 0, 1, 0, 0, 0, "R1");
    step(0, 1, 2, 3, 0, 0, 0, "R1");
    // R3 + R5: r2 = r2 op r3 reads old r2; tags 4..7 in order
    step(1, 1, 2, 3, 2, 0, 0, "R3");
    step(1, 1, 2, 1, 2, 0, 0, "R5");
    step(1, 1, 2, 2, 2, 0, 0, "R5");
    step(1, 1, 1, 2, 1, 0, 0, "R5");
    // R2/R4: latest writers visible
    step(0, 0, 2, 1, 0, 0, 0, "R4");
    // R6: empty list stalls; r3 must stay bound to 3
    step(1, 1, 3, 0, 3, 0, 0, "R6");
    step(0, 0, 3, 2, 0, 0, 0, "R6");
    // R7: no destination still accepted when empty
    step(1, 0, 1, 3, 3, 0, 0, "R7");
    step(0, 0, 3, 1, 0, 0, 0, "R7");
    // R8: released tags come back in release order
    step(0, 0, 0, 0, 0, 1, 2, "R8");
    step(0, 0, 0, 0, 0, 1, 1, "R8");
    step(1, 1, 0, 3, 0, 0, 0, "R8");
    step(1, 1, 3, 0, 3, 0, 0, "R8");
    step(0, 0, 0, 3, 0, 0, 0, "R8");
    // R9: release alongside allocation
    step(0, 0, 0, 0, 0, 1, 5, "R9");
    step(1, 1, 1, 0, 0, 1, 4, "R9");
    step(1, 1, 0, 2, 1, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 0, 0, "R9");

    // Rebuild the pool of tags that may legally be returned.
    retire.delete();
    for (int t = 0; t < NP; t++) begin
      bit used = 0;
      foreach (mdl_map[i]) if (mdl_map[i] == t) used = 1;
      foreach (fl[i]) if (fl[i] == t) used = 1;
      if (!used) retire.push_back(t);
    end

    // R2: mixed traffic with retirement
    for (int n = 0; n < 400; n++) begin
      bit rv = (retire.size() > 0) && ($urandom % 3 != 0);
      int rt = rv ? retire[0] : 0;
      if (rv) void'(retire.pop_front());
      step(($urandom % 4) != 0, ($urandom % 4) != 0, $urandom % NA, $urandom % NA,
           $urandom % NA, rv, rt, "R2");
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule